// File: doc/BRIEF.md
# Lock-Aware Fixed-Priority Bus Arbiter

This block picks a single owner for a shared bus out of the masters that are asking for it in the same cycle. Each master drives a request bit and a lock bit. Each master also has a static priority number on a packed input. The arbiter decides only while the bus is free, that is, when no earlier grant is still being served, and only when at least one request is present. It announces the winner with a one-hot grant vector and a one-cycle valid strobe. The bus side reports the end of a transfer with a completion pulse.

A master that holds a lock keeps the bus. If it asks again it wins again, ahead of every priority number. This also applies to a master whose previous grant was taken with its lock bit set, even if its lock bit has since dropped. When no lock rule applies, the requester with the smallest priority number wins. The arbiter checks that priority numbers are unique. If two requesters share a number when a decision is due, the arbiter issues no grant and raises an error flag. That flag stays set until reset, and no further grant is issued while it is set. The arbiter stores no requests: a master that loses keeps its request bit high and is considered again at the next decision.

Top module: `lock_prio_arbiter`

## Requirements
- R1: At a decision, if the previous owner is requesting and its lock input is high, it is granted regardless of priority numbers.
- R2: At a decision, if the previous owner is requesting and it was granted with its lock input high, it is granted again even if its lock input is now low; the stored lock flag then takes the current lock value of the new grant.
- R3: When neither R1 nor R2 applies, the requesting master with the smallest priority number wins; the number of master i is `prio[i*PRIO_W +: PRIO_W]` (unsigned).
- R4: If any two requesting masters have equal priority numbers when a decision is due, no grant is issued and `dup_err` goes high one cycle later. This applies whichever rule would have chosen the winner.
- R5: `dup_err` stays high until reset, and while it is high `grant_valid` stays low for any request pattern.
- R6: A decision is due only on a clock edge where no grant is outstanding and `req` is non-zero. A grant is outstanding from its decision edge until the edge where `bus_done` is sampled high, so the next grant can appear at the earliest one cycle after that edge.
- R7: After a decision at edge E, `grant` is one-hot and `grant_valid` is high for exactly the one cycle following E. In all other cycles `grant` is zero and `grant_valid` is low.
- R8: Reset clears the grant, the error flag, the outstanding-transfer state and the record of the previous owner, so the first decision after reset uses priority numbers only.
- R9: Masters that lose a decision and keep their request high take part in the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MASTERS | Request bit per master |
| lock | input | N_MASTERS | Lock bit per master |
| prio | input | N_MASTERS*PRIO_W | Packed static priority numbers, master i at bits i*PRIO_W upward |
| bus_done | input | 1 | Pulse marking completion of the outstanding grant |
| grant | output | N_MASTERS | One-hot winner, valid with grant_valid |
| grant_valid | output | 1 | One-cycle strobe for a new grant |
| dup_err | output | 1 | Sticky duplicate-priority error |

## Verification
The bench builds the arbiter with three masters and two-bit priority numbers. This makes the full space of 64 priority assignments times 7 non-empty request patterns small enough to sweep completely. Each case starts from reset and is compared with a minimum-search and pairwise-equality computed in the bench. The small size also keeps lock handover, busy holding, held losing requests and the sticky error reachable in short directed sequences. Those sequences count the exact cycles between the completion pulse and the next grant.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  // Which rule produced the winner at a decision edge
  typedef enum logic [1:0] {
    SRC_NONE      = 2'd0,
    SRC_LOCK_NOW  = 2'd1,
    SRC_LOCK_PREV = 2'd2,
    SRC_PRIO      = 2'd3
  } win_src_e;
endpackage

// File: rtl/lpa_prio_pick.sv
module lpa_prio_pick #(
  parameter int N_MASTERS = 4,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0]        req,
  input  logic [N_MASTERS*PRIO_W-1:0] prio,
  output logic [IDX_W-1:0]            pick_idx,
  output logic                        pick_any
);

  function automatic logic [PRIO_W-1:0] prio_of(
    input logic [N_MASTERS*PRIO_W-1:0] vec, input int idx);
    return vec[idx*PRIO_W +: PRIO_W];
  endfunction

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    pick_idx = '0;
    pick_any = 1'b0;
    best_p   = '1;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (req[i] && (!pick_any || (prio_of(prio, i) < best_p))) begin
        pick_any = 1'b1;
        best_p   = prio_of(prio, i);
        pick_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/lpa_dup_check.sv
module lpa_dup_check #(
  parameter int N_MASTERS = 4,
  parameter int PRIO_W    = 3
) (
  input  logic [N_MASTERS-1:0]        req,
  input  logic [N_MASTERS*PRIO_W-1:0] prio,
  output logic                        dup
);

  function automatic logic clash(input logic ra, input logic rb,
                                 input logic [PRIO_W-1:0] pa,
                                 input logic [PRIO_W-1:0] pb);
    return ra && rb && (pa == pb);
  endfunction

  logic [N_MASTERS*N_MASTERS-1:0] pair_hit;

  for (genvar gi = 0; gi < N_MASTERS; gi++) begin : g_row
    for (genvar gj = 0; gj < N_MASTERS; gj++) begin : g_col
      if (gj > gi) begin : g_pair
        assign pair_hit[gi*N_MASTERS+gj] =
          clash(req[gi], req[gj], prio[gi*PRIO_W +: PRIO_W], prio[gj*PRIO_W +: PRIO_W]);
      end else begin : g_none
        assign pair_hit[gi*N_MASTERS+gj] = 1'b0;
      end
    end
  end

  assign dup = |pair_hit;

endmodule

// File: rtl/lpa_owner_track.sv
module lpa_owner_track #(
  parameter int N_MASTERS = 4,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             win_lock,
  input  logic             bus_done,
  output logic             busy,
  output logic             last_valid,
  output logic [IDX_W-1:0] last_idx,
  output logic             last_lock
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      last_valid <= 1'b0;
      last_idx   <= '0;
      last_lock  <= 1'b0;
    end else begin
      if (fire) begin
        busy       <= 1'b1;
        last_valid <= 1'b1;
        last_idx   <= win_idx;
        last_lock  <= win_lock;
      end else if (bus_done) begin
        busy <= 1'b0;
      end
    end
  end

  // R6
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_done) |=> busy);

  // R6
  no_fire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);

  // R2
  lock_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (last_valid && last_lock == $past(win_lock) && last_idx == $past(win_idx)));

endmodule

// File: rtl/lock_prio_arbiter.sv
module lock_prio_arbiter #(
  parameter int N_MASTERS = 4,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_MASTERS-1:0]        req,
  input  logic [N_MASTERS-1:0]        lock,
  input  logic [N_MASTERS*PRIO_W-1:0] prio,
  input  logic                        bus_done,
  output logic [N_MASTERS-1:0]        grant,
  output logic                        grant_valid,
  output logic                        dup_err
);
  import lpa_pkg::*;

  function automatic logic [N_MASTERS-1:0] to_onehot(input logic [IDX_W-1:0] idx);
    logic [N_MASTERS-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  logic             busy, last_valid, last_lock;
  logic [IDX_W-1:0] last_idx, pick_idx, win_idx;
  logic             pick_any, dup;
  logic             free, arb_evt, fire, clash_evt;
  logic             hold_now, hold_prev, owner_req;
  win_src_e         src;

  lpa_prio_pick #(.N_MASTERS(N_MASTERS), .PRIO_W(PRIO_W)) u_pick (
    .req(req), .prio(prio), .pick_idx(pick_idx), .pick_any(pick_any));

  lpa_dup_check #(.N_MASTERS(N_MASTERS), .PRIO_W(PRIO_W)) u_dup (
    .req(req), .prio(prio), .dup(dup));

  lpa_owner_track #(.N_MASTERS(N_MASTERS)) u_owner (
    .clk(clk), .rst_n(rst_n), .fire(fire), .win_idx(win_idx),
    .win_lock(lock[win_idx]), .bus_done(bus_done), .busy(busy),
    .last_valid(last_valid), .last_idx(last_idx), .last_lock(last_lock));

  assign owner_req = last_valid && req[last_idx];
  assign hold_now  = owner_req && lock[last_idx];
  assign hold_prev = owner_req && last_lock;

  always_comb begin
    if (hold_now)       src = SRC_LOCK_NOW;
    else if (hold_prev) src = SRC_LOCK_PREV;
    else if (pick_any)  src = SRC_PRIO;
    else                src = SRC_NONE;
  end

  assign win_idx   = (src == SRC_PRIO) ? pick_idx : last_idx;
  assign free      = !busy && !dup_err;
  assign arb_evt   = free && (src != SRC_NONE);
  assign clash_evt = arb_evt && dup;
  assign fire      = arb_evt && !dup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
      dup_err     <= 1'b0;
    end else begin
      grant       <= fire ? to_onehot(win_idx) : '0;
      grant_valid <= fire;
      if (clash_evt) dup_err <= 1'b1;
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(grant) == 1));

  // R7
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant == '0));

  // R7
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |=> dup_err);

  // R5
  no_grant_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> !grant_valid);

  // R4
  clash_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash_evt |=> (dup_err && !grant_valid));

  // R6
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_done) |=> !grant_valid);

  // R1
  lock_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hold_now) |=> (grant_valid && last_idx == $past(last_idx)));

  // R3
  prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && src == SRC_PRIO) |-> req[pick_idx]);

endmodule

// File: tb/tb_lock_prio_arbiter.sv
`timescale 1ns/1ps
module tb_lock_prio_arbiter;
  localparam int N = 3;
  localparam int W = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   req, lock;
  logic [N*W-1:0] prio;
  logic           bus_done;
  logic [N-1:0]   grant;
  logic           grant_valid, dup_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lock_prio_arbiter #(.N_MASTERS(N), .PRIO_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .prio(prio),
    .bus_done(bus_done), .grant(grant), .grant_valid(grant_valid), .dup_err(dup_err));

  task automatic chk(input string tag, input logic [N+1:0] act, input logic [N+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual valid/err/grant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; lock = '0; bus_done = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at a negedge, sample the registered result one cycle later
  task automatic arb(input string tag, input logic [N-1:0] r, input logic [N-1:0] l,
                     input logic ev, input logic ee, input logic [N-1:0] eg);
    req = r; lock = l;
    @(negedge clk);
    chk(tag, {grant_valid, dup_err, grant}, {ev, ee, eg});
  endtask

  task automatic finish_xfer(input string tag);
    req = '0; lock = '0; bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    chk(tag, {grant_valid, dup_err, grant}, {1'b0, dup_err, {N{1'b0}}});
  endtask

  // expected winner by priority search, independent formulation
  function automatic logic [N-1:0] exp_prio(input logic [N-1:0] r, input logic [N*W-1:0] p);
    int best = -1;
    int bv = 1 << W;
    for (int i = 0; i < N; i++) begin
      int v = int'(p[i*W +: W]);
      if (r[i] && v < bv) begin bv = v; best = i; end
    end
    return (best < 0) ? '0 : (N'(1) << best);
  endfunction

  function automatic logic exp_dup(input logic [N-1:0] r, input logic [N*W-1:0] p);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && r[i] && r[j] && p[i*W +: W] == p[j*W +: W]) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    prio = 6'b00_01_10;  // m0=2, m1=1, m2=0
    do_reset();
    // R8 reset state
    chk("R8 reset", {grant_valid, dup_err, grant}, '0);

    // R8: lock on m0 but no previous owner -> priority picks m2
    arb("R8 first decision", 3'b111, 3'b001, 1'b1, 1'b0, 3'b100);
    finish_xfer("R7 pulse");
    arb("R3 lone m0 locked", 3'b001, 3'b001, 1'b1, 1'b0, 3'b001);
    finish_xfer("R7 pulse");
    // R1 locked owner keeps bus
    arb("R1 lock now", 3'b111, 3'b001, 1'b1, 1'b0, 3'b001);
    finish_xfer("R7 pulse");
    // R2 lock dropped now, but previous grant was locked
    arb("R2 lock prev", 3'b111, 3'b000, 1'b1, 1'b0, 3'b001);
    finish_xfer("R7 pulse");
    // R3 stored lock now clear
    arb("R3 lock released", 3'b111, 3'b000, 1'b1, 1'b0, 3'b100);
    finish_xfer("R7 pulse");

    // R3 locked owner absent
    do_reset();
    arb("R3 setup", 3'b001, 3'b001, 1'b1, 1'b0, 3'b001);
    finish_xfer("R7 pulse");
    arb("R3 owner absent", 3'b110, 3'b001, 1'b1, 1'b0, 3'b100);
    finish_xfer("R7 pulse");

    // R9 loser stays pending, R6 next grant one cycle after done edge
    do_reset();
    arb("R9 first", 3'b011, 3'b000, 1'b1, 1'b0, 3'b010);
    req = 3'b001; bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    chk("R6 not same edge as done", {grant_valid, dup_err, grant}, '0);
    @(negedge clk);
    chk("R9 loser granted", {grant_valid, dup_err, grant}, {2'b10, 3'b001});
    finish_xfer("R7 pulse");

    // R6 busy holds off decisions
    do_reset();
    arb("R6 setup", 3'b100, 3'b000, 1'b1, 1'b0, 3'b100);
    req = 3'b011;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R6 busy no grant", {grant_valid, dup_err, grant}, '0);
    end
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    chk("R6 done edge", {grant_valid, dup_err, grant}, '0);
    @(negedge clk);
    chk("R6 after done", {grant_valid, dup_err, grant}, {2'b10, 3'b010});
    finish_xfer("R7 pulse");

    // R4 / R5 duplicate priority, sticky
    prio = 6'b00_01_01;  // m0=1, m1=1, m2=0
    do_reset();
    arb("R4 dup", 3'b011, 3'b000, 1'b0, 1'b1, 3'b000);
    req = 3'b100;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 sticky no grant", {grant_valid, dup_err, grant}, {2'b01, 3'b000});
    end
    do_reset();
    chk("R8 reset clears err", {grant_valid, dup_err, grant}, '0);
    // R4 dup even on lock path
    arb("R4 setup", 3'b001, 3'b001, 1'b1, 1'b0, 3'b001);
    finish_xfer("R7 pulse");
    arb("R4 dup with lock", 3'b011, 3'b001, 1'b0, 1'b1, 3'b000);

    // R3 R4 exhaustive sweep
    for (int p = 0; p < 64; p++) begin
      for (int r = 1; r < 8; r++) begin
        logic d;
        prio = 6'(p);
        do_reset();
        d = exp_dup(3'(r), 6'(p));
        arb(d ? "R4 sweep" : "R3 sweep", 3'(r), 3'b000, !d, d,
            d ? 3'b000 : exp_prio(3'(r), 6'(p)));
        @(negedge clk);
        chk("R7 sweep pulse", {grant_valid, dup_err, grant}, {1'b0, d, 3'b000});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule